// File: doc/BRIEF.md
# VPD Capability Access Engine

This block runs Vital Product Data transfers through a device's VPD capability on behalf of a host-side user. The capability exposes two configuration registers. One is a 16-bit address register whose bit 15 is a completion flag. The other is a 32-bit data register. The engine reaches both through a simple request/acknowledge configuration master.

A read request gives a byte position and a byte count. The engine splits it into dword-aligned transactions. For each one it writes the address, polls the flag and reads the data register. It then streams out only the requested bytes, one per cycle. A write request moves whole dwords, taken from a word input. For each dword the engine loads the data register, then writes the address with the flag set, then polls until the device clears the flag.

Polling backs off exponentially and is bounded by a timeout. Requests that fall outside the VPD space are clipped or rejected. Every request ends with exactly one done or error pulse. Timing is expressed in microseconds and converted to clock cycles through a parameter.

Top module: `vpd_xfer_engine`

## Requirements
- R1: For each read dword, the engine first writes the address register with bits [1:0] cleared and bit 15 at 0. The address field holds the current position rounded down to a multiple of 4.
- R2: The data register is read only after a status read of the address register has returned bit 15 as 1.
- R3: Bytes come out of each data dword in lane order, starting with bits [7:0]. The first dword drops its lower (position mod 4) lanes. Output stops after the last requested byte.
- R4: A read whose end passes MAX_LEN is cut at MAX_LEN. The done pulse then reports the shortened byte count.
- R5: A read that starts at or beyond MAX_LEN, or asks for zero bytes, ends with done and a count of 0. It makes no configuration access.
- R6: A write is rejected with err and err_code 1, and makes no configuration access, if any of these holds: the position is not a multiple of 4, the count is not a multiple of 4, or position plus count exceeds MAX_LEN.
- R7: Each write dword is handled in order. The engine writes the data register with wd_word (byte 0 of the dword in bits [7:0]) and pulses wd_take. It then writes the address with bit 15 set. It then polls until bit 15 reads 0.
- R8: A poll that has not seen the expected flag value after TIMEOUT_US microseconds aborts the transfer with err_code 2.
- R9: The wait between two status reads of one poll starts at FIRST_GAP_US. It doubles after each wait until it reaches MAX_GAP_US, and then stays there.
- R10: A configuration access acknowledged with cfg_err ends the transfer at once with err_code 3. No further access follows.
- R11: busy rises when a command is accepted and falls in the cycle the done or err pulse is raised. Commands presented while busy is high are ignored.
- R12: done and err are never high together. On done, xfer_count holds the number of bytes transferred. cfg_req stays high with stable data until cfg_ack.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cmd_valid | input | 1 | Command strobe, taken when busy is low |
| cmd_write | input | 1 | 1 = write request, 0 = read request |
| cmd_pos | input | LEN_W | Start byte position |
| cmd_count | input | LEN_W | Byte count |
| wd_word | input | 32 | Next write dword, byte 0 in bits [7:0] |
| wd_take | output | 1 | Pulse: current wd_word has been consumed |
| busy | output | 1 | Transfer in progress |
| rd_valid | output | 1 | A read byte is on rd_byte |
| rd_byte | output | 8 | Read data byte |
| done | output | 1 | Pulse: request finished without error |
| err | output | 1 | Pulse: request aborted |
| err_code | output | 2 | 1 range, 2 timeout, 3 config failure |
| xfer_count | output | LEN_W | Bytes transferred, valid with done |
| cfg_req | output | 1 | Configuration access request |
| cfg_we | output | 1 | 1 = write access |
| cfg_sel | output | 1 | 0 = address register, 1 = data register |
| cfg_wdata | output | 32 | Write data for the access |
| cfg_ack | input | 1 | Access complete |
| cfg_err | input | 1 | Access failed, valid with cfg_ack |
| cfg_rdata | input | 32 | Read data, valid with cfg_ack |

## Verification
Each read byte appears one cycle after the previous one. The first byte appears two cycles after the data-register acknowledge. The done pulse follows the last byte by at least two cycles. The bench samples every output on the falling edge. Its scoreboard consumes bytes as they appear, rather than at fixed offsets, and each request is closed by waiting for its own done or err pulse. Poll spacing is judged from the differences between successive status-read intervals, which cancels the fixed handshake overhead and leaves only the doubling gap. The timeout is checked against a window measured from the first status read.

// File: rtl/vpd_pkg.sv
package vpd_pkg;
  typedef enum logic [1:0] {
    ERR_NONE    = 2'd0,
    ERR_RANGE   = 2'd1,
    ERR_TIMEOUT = 2'd2,
    ERR_BUS     = 2'd3
  } err_e;

  localparam int FLAG_BIT = 15;
  localparam int CAP_AW   = 15;
  localparam logic SEL_ADDR = 1'b0;
  localparam logic SEL_DATA = 1'b1;
endpackage

// File: rtl/vpd_req_check.sv
module vpd_req_check #(
  parameter int LEN_W   = 16,
  parameter int MAX_LEN = 32768
) (
  input  logic             is_write,
  input  logic [LEN_W-1:0] pos,
  input  logic [LEN_W-1:0] count,
  output logic [LEN_W:0]   end_pos,
  output logic [LEN_W-1:0] eff_count,
  output logic             reject,
  output logic             empty
);
  localparam int EW = LEN_W + 1;
  localparam logic [EW-1:0] LIMIT = EW'(MAX_LEN);

  logic [EW-1:0] raw_end;
  logic [EW-1:0] clip_end;

  assign raw_end  = {1'b0, pos} + {1'b0, count};
  assign clip_end = (raw_end > LIMIT) ? LIMIT : raw_end;

  always_comb begin
    reject    = 1'b0;
    empty     = 1'b0;
    end_pos   = raw_end;
    eff_count = count;
    if (is_write) begin
      reject = (pos[1:0] != 2'b00) || (count[1:0] != 2'b00) || (raw_end > LIMIT);
      empty  = (count == '0);
    end else if ({1'b0, pos} >= LIMIT) begin
      empty     = 1'b1;
      eff_count = '0;
    end else begin
      end_pos   = clip_end;
      eff_count = LEN_W'(clip_end - {1'b0, pos});
      empty     = (eff_count == '0);
    end
  end
endmodule

// File: rtl/vpd_poll_timer.sv
module vpd_poll_timer #(
  parameter int CLK_PER_US   = 100,
  parameter int TIMEOUT_US   = 125000,
  parameter int FIRST_GAP_US = 16,
  parameter int MAX_GAP_US   = 1024
) (
  input  logic clk,
  input  logic rst,
  input  logic start,
  input  logic wait_go,
  output logic expired,
  output logic wait_done
);
  localparam int unsigned LIMIT = TIMEOUT_US * CLK_PER_US;
  localparam int unsigned GAP0  = FIRST_GAP_US * CLK_PER_US;
  localparam int unsigned GAPM  = MAX_GAP_US * CLK_PER_US;
  localparam int TW = $clog2(LIMIT + 1);
  localparam int GW = $clog2(GAPM + 1) + 1;

  logic [TW-1:0] elapsed;
  logic [GW-1:0] gap;
  logic [GW-1:0] wcnt;
  logic          waiting;

  assign expired = (elapsed == TW'(LIMIT));

  always_ff @(posedge clk) begin
    if (rst) begin
      elapsed   <= '0;
      gap       <= GW'(GAP0);
      wcnt      <= '0;
      waiting   <= 1'b0;
      wait_done <= 1'b0;
    end else begin
      wait_done <= 1'b0;
      if (start) begin
        elapsed <= '0;
        gap     <= GW'(GAP0);
      end else if (!expired) begin
        elapsed <= elapsed + 1'b1;
      end
      if (wait_go) begin
        wcnt    <= gap - 1'b1;
        waiting <= 1'b1;
        gap     <= (gap > (GW'(GAPM) - gap)) ? GW'(GAPM) : (gap << 1);
      end else if (waiting) begin
        if (wcnt == '0) begin
          waiting   <= 1'b0;
          wait_done <= 1'b1;
        end else begin
          wcnt <= wcnt - 1'b1;
        end
      end
    end
  end
endmodule

// File: rtl/vpd_lane_unpack.sv
module vpd_lane_unpack (
  input  logic        clk,
  input  logic        rst,
  input  logic        load,
  input  logic [31:0] word,
  input  logic [1:0]  first_lane,
  input  logic [1:0]  last_lane,
  output logic        active,
  output logic        byte_valid,
  output logic [7:0]  byte_data
);
  logic [31:0] word_q;
  logic [1:0]  lane;
  logic [1:0]  last_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      word_q     <= '0;
      lane       <= '0;
      last_q     <= '0;
      active     <= 1'b0;
      byte_valid <= 1'b0;
      byte_data  <= '0;
    end else begin
      byte_valid <= 1'b0;
      if (load) begin
        word_q <= word;
        lane   <= first_lane;
        last_q <= last_lane;
        active <= 1'b1;
      end else if (active) begin
        byte_valid <= 1'b1;
        byte_data  <= word_q[{lane, 3'b000} +: 8];
        lane       <= lane + 2'd1;
        if (lane == last_q) active <= 1'b0;
      end
    end
  end
endmodule

// File: rtl/vpd_xfer_engine.sv
module vpd_xfer_engine
  import vpd_pkg::*;
#(
  parameter int LEN_W        = 16,
  parameter int MAX_LEN      = 32768,
  parameter int CLK_PER_US   = 100,
  parameter int TIMEOUT_US   = 125000,
  parameter int FIRST_GAP_US = 16,
  parameter int MAX_GAP_US   = 1024
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             cmd_valid,
  input  logic             cmd_write,
  input  logic [LEN_W-1:0] cmd_pos,
  input  logic [LEN_W-1:0] cmd_count,
  input  logic [31:0]      wd_word,
  output logic             wd_take,
  output logic             busy,
  output logic             rd_valid,
  output logic [7:0]       rd_byte,
  output logic             done,
  output logic             err,
  output logic [1:0]       err_code,
  output logic [LEN_W-1:0] xfer_count,
  output logic             cfg_req,
  output logic             cfg_we,
  output logic             cfg_sel,
  output logic [31:0]      cfg_wdata,
  input  logic             cfg_ack,
  input  logic             cfg_err,
  input  logic [31:0]      cfg_rdata
);
  localparam int EW = LEN_W + 1;

  typedef enum logic [3:0] {
    S_IDLE, S_RD_ADDR, S_POLL, S_GAP, S_RD_DATA, S_EMIT,
    S_WR_DATA, S_WR_ADDR, S_FINISH, S_FAIL
  } state_e;

  state_e           state;
  logic             wr_q;
  logic             want_q;
  logic [EW-1:0]    cur;
  logic [EW-1:0]    endp;
  logic [LEN_W-1:0] total;
  err_e             code_q;

  // request range decode
  logic [EW-1:0]    rc_end;
  logic [LEN_W-1:0] rc_cnt;
  logic             rc_reject;
  logic             rc_empty;

  vpd_req_check #(.LEN_W(LEN_W), .MAX_LEN(MAX_LEN)) u_req_check (
    .is_write  (cmd_write),
    .pos       (cmd_pos),
    .count     (cmd_count),
    .end_pos   (rc_end),
    .eff_count (rc_cnt),
    .reject    (rc_reject),
    .empty     (rc_empty)
  );

  // poll pacing
  logic acc_ok;
  logic flag_seen;
  logic tmr_start;
  logic tmr_wait;
  logic tmr_exp;
  logic tmr_done;

  assign acc_ok    = cfg_ack & ~cfg_err;
  assign flag_seen = cfg_rdata[FLAG_BIT];
  assign tmr_start = acc_ok && ((state == S_RD_ADDR) || (state == S_WR_ADDR));
  assign tmr_wait  = acc_ok && (state == S_POLL) && (flag_seen != want_q) && !tmr_exp;

  vpd_poll_timer #(
    .CLK_PER_US   (CLK_PER_US),
    .TIMEOUT_US   (TIMEOUT_US),
    .FIRST_GAP_US (FIRST_GAP_US),
    .MAX_GAP_US   (MAX_GAP_US)
  ) u_poll_timer (
    .clk       (clk),
    .rst       (rst),
    .start     (tmr_start),
    .wait_go   (tmr_wait),
    .expired   (tmr_exp),
    .wait_done (tmr_done)
  );

  // dword bookkeeping
  logic [EW-1:0] cur_base;
  logic [EW-1:0] next_base;
  logic [EW-1:0] remain;
  logic [1:0]    last_lane;
  logic          up_load;
  logic          up_active;

  assign cur_base  = {cur[EW-1:2], 2'b00};
  assign next_base = cur_base + EW'(4);
  assign remain    = endp - cur_base;
  assign last_lane = (remain <= EW'(4)) ? (endp[1:0] - 2'd1) : 2'd3;
  assign up_load   = acc_ok && (state == S_RD_DATA);

  vpd_lane_unpack u_lane_unpack (
    .clk        (clk),
    .rst        (rst),
    .load       (up_load),
    .word       (cfg_rdata),
    .first_lane (cur[1:0]),
    .last_lane  (last_lane),
    .active     (up_active),
    .byte_valid (rd_valid),
    .byte_data  (rd_byte)
  );

  function automatic logic [31:0] addr_word(input logic [EW-1:0] a, input logic flag);
    return {16'h0000, flag, a[CAP_AW-1:2], 2'b00};
  endfunction

  always_ff @(posedge clk) begin
    if (rst) begin
      state      <= S_IDLE;
      wr_q       <= 1'b0;
      want_q     <= 1'b0;
      cur        <= '0;
      endp       <= '0;
      total      <= '0;
      code_q     <= ERR_NONE;
      busy       <= 1'b0;
      done       <= 1'b0;
      err        <= 1'b0;
      err_code   <= ERR_NONE;
      xfer_count <= '0;
      wd_take    <= 1'b0;
      cfg_req    <= 1'b0;
      cfg_we     <= 1'b0;
      cfg_sel    <= SEL_ADDR;
      cfg_wdata  <= '0;
    end else begin
      done    <= 1'b0;
      err     <= 1'b0;
      wd_take <= 1'b0;
      if (cfg_ack) cfg_req <= 1'b0;
      unique case (state)
        S_IDLE: begin
          if (cmd_valid) begin
            busy  <= 1'b1;
            wr_q  <= cmd_write;
            cur   <= {1'b0, cmd_pos};
            endp  <= rc_end;
            total <= rc_cnt;
            if (rc_reject) begin
              code_q <= ERR_RANGE;
              state  <= S_FAIL;
            end else if (rc_empty) begin
              total <= '0;
              state <= S_FINISH;
            end else if (cmd_write) begin
              cfg_req   <= 1'b1;
              cfg_we    <= 1'b1;
              cfg_sel   <= SEL_DATA;
              cfg_wdata <= wd_word;
              state     <= S_WR_DATA;
            end else begin
              cfg_req   <= 1'b1;
              cfg_we    <= 1'b1;
              cfg_sel   <= SEL_ADDR;
              cfg_wdata <= addr_word({1'b0, cmd_pos}, 1'b0);
              state     <= S_RD_ADDR;
            end
          end
        end
        S_RD_ADDR, S_WR_ADDR: begin
          if (cfg_ack) begin
            if (cfg_err) begin
              code_q <= ERR_BUS;
              state  <= S_FAIL;
            end else begin
              want_q    <= (state == S_RD_ADDR);
              cfg_req   <= 1'b1;
              cfg_we    <= 1'b0;
              cfg_sel   <= SEL_ADDR;
              cfg_wdata <= '0;
              state     <= S_POLL;
            end
          end
        end
        S_POLL: begin
          if (cfg_ack) begin
            if (cfg_err) begin
              code_q <= ERR_BUS;
              state  <= S_FAIL;
            end else if (flag_seen == want_q) begin
              if (!wr_q) begin
                cfg_req <= 1'b1;
                cfg_we  <= 1'b0;
                cfg_sel <= SEL_DATA;
                state   <= S_RD_DATA;
              end else begin
                cur <= next_base;
                if (next_base >= endp) begin
                  state <= S_FINISH;
                end else begin
                  cfg_req   <= 1'b1;
                  cfg_we    <= 1'b1;
                  cfg_sel   <= SEL_DATA;
                  cfg_wdata <= wd_word;
                  state     <= S_WR_DATA;
                end
              end
            end else if (tmr_exp) begin
              code_q <= ERR_TIMEOUT;
              state  <= S_FAIL;
            end else begin
              state <= S_GAP;
            end
          end
        end
        S_GAP: begin
          if (tmr_done) begin
            cfg_req <= 1'b1;
            cfg_we  <= 1'b0;
            cfg_sel <= SEL_ADDR;
            state   <= S_POLL;
          end
        end
        S_RD_DATA: begin
          if (cfg_ack) begin
            if (cfg_err) begin
              code_q <= ERR_BUS;
              state  <= S_FAIL;
            end else begin
              state <= S_EMIT;
            end
          end
        end
        S_EMIT: begin
          if (!up_active) begin
            cur <= next_base;
            if (next_base >= endp) begin
              state <= S_FINISH;
            end else begin
              cfg_req   <= 1'b1;
              cfg_we    <= 1'b1;
              cfg_sel   <= SEL_ADDR;
              cfg_wdata <= addr_word(next_base, 1'b0);
              state     <= S_RD_ADDR;
            end
          end
        end
        S_WR_DATA: begin
          if (cfg_ack) begin
            if (cfg_err) begin
              code_q <= ERR_BUS;
              state  <= S_FAIL;
            end else begin
              wd_take   <= 1'b1;
              cfg_req   <= 1'b1;
              cfg_we    <= 1'b1;
              cfg_sel   <= SEL_ADDR;
              cfg_wdata <= addr_word(cur, 1'b1);
              state     <= S_WR_ADDR;
            end
          end
        end
        S_FINISH: begin
          done       <= 1'b1;
          busy       <= 1'b0;
          err_code   <= ERR_NONE;
          xfer_count <= total;
          state      <= S_IDLE;
        end
        S_FAIL: begin
          err        <= 1'b1;
          busy       <= 1'b0;
          err_code   <= code_q;
          xfer_count <= '0;
          state      <= S_IDLE;
        end
        default: state <= S_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/vpd_xfer_checker.sv
module vpd_xfer_checker (
  input logic        clk,
  input logic        rst,
  input logic        busy,
  input logic        rd_valid,
  input logic        done,
  input logic        err,
  input logic [1:0]  err_code,
  input logic        cfg_req,
  input logic        cfg_we,
  input logic        cfg_sel,
  input logic [31:0] cfg_wdata,
  input logic        cfg_ack
);
  AST_READ_ADDR_ALIGNED: assert property (@(posedge clk) disable iff (rst)
    (cfg_req && cfg_we && !cfg_sel && !cfg_wdata[15]) |-> (cfg_wdata[1:0] == 2'b00)); // R1
  AST_WRITE_ADDR_ALIGNED: assert property (@(posedge clk) disable iff (rst)
    (cfg_req && cfg_we && !cfg_sel && cfg_wdata[15]) |-> (cfg_wdata[1:0] == 2'b00)); // R7
  AST_ERR_HAS_CODE: assert property (@(posedge clk) disable iff (rst)
    err |-> (err_code != 2'd0)); // R10
  AST_BYTE_WHILE_BUSY: assert property (@(posedge clk) disable iff (rst)
    rd_valid |-> busy); // R11
  AST_END_DROPS_BUSY: assert property (@(posedge clk) disable iff (rst)
    (done || err) |-> (!busy && $past(busy))); // R11
  AST_DONE_ERR_EXCL: assert property (@(posedge clk) disable iff (rst)
    !(done && err)); // R12
  AST_REQ_HELD: assert property (@(posedge clk) disable iff (rst)
    (cfg_req && !cfg_ack) |=> (cfg_req && $stable(cfg_wdata) && $stable(cfg_sel))); // R12
endmodule

bind vpd_xfer_engine vpd_xfer_checker i_vpd_xfer_checker (
  .clk       (clk),
  .rst       (rst),
  .busy      (busy),
  .rd_valid  (rd_valid),
  .done      (done),
  .err       (err),
  .err_code  (err_code),
  .cfg_req   (cfg_req),
  .cfg_we    (cfg_we),
  .cfg_sel   (cfg_sel),
  .cfg_wdata (cfg_wdata),
  .cfg_ack   (cfg_ack)
);

// File: tb/test_vpd_xfer_engine.sv
module test_vpd_xfer_engine;
  localparam int LW = 16;
  localparam int MAXL = 64;

  logic clk = 1'b0;
  logic rst = 1'b1;
  always #5 clk = ~clk;

  logic          cmd_valid = 1'b0, cmd_write = 1'b0;
  logic [LW-1:0] cmd_pos = '0, cmd_count = '0;
  logic [31:0]   wd_word = '0;
  logic          wd_take, busy, rd_valid, done, err;
  logic [7:0]    rd_byte;
  logic [1:0]    err_code;
  logic [LW-1:0] xfer_count;
  logic          cfg_req, cfg_we, cfg_sel;
  logic [31:0]   cfg_wdata;
  logic          cfg_ack = 1'b0, cfg_err = 1'b0;
  logic [31:0]   cfg_rdata = '0;

  vpd_xfer_engine #(.LEN_W(LW), .MAX_LEN(MAXL), .CLK_PER_US(1), .TIMEOUT_US(300),
                    .FIRST_GAP_US(2), .MAX_GAP_US(8)) i_vpd_xfer_engine (
    .clk(clk), .rst(rst), .cmd_valid(cmd_valid), .cmd_write(cmd_write),
    .cmd_pos(cmd_pos), .cmd_count(cmd_count), .wd_word(wd_word), .wd_take(wd_take),
    .busy(busy), .rd_valid(rd_valid), .rd_byte(rd_byte), .done(done), .err(err),
    .err_code(err_code), .xfer_count(xfer_count), .cfg_req(cfg_req), .cfg_we(cfg_we),
    .cfg_sel(cfg_sel), .cfg_wdata(cfg_wdata), .cfg_ack(cfg_ack), .cfg_err(cfg_err),
    .cfg_rdata(cfg_rdata));

  int total = 0, bad = 0;
  task automatic chk(input bit ok, input string req, input string what, input longint act, input longint exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  // device model
  logic [7:0]  mem [MAXL];
  logic [15:0] m_addr = '0;
  logic        m_flag = 1'b0, pending = 1'b0, fresh = 1'b0;
  logic [31:0] m_data = '0;
  int polls = 0, flip_after = 0, err_mode = 0, acc_cnt = 0, viol_flag = 0, viol_order = 0;
  int first_addr = -1, cyc = 0;
  bit hang = 0;
  int poll_t[$];

  always @(posedge clk) begin
    cyc++;
    cfg_ack <= 1'b0;
    cfg_err <= 1'b0;
    if (!rst && cfg_req && !cfg_ack) begin
      int a;
      cfg_ack <= 1'b1;
      acc_cnt++;
      a = int'(m_addr[5:0]) & 60;
      if (err_mode == 2 && !cfg_we && cfg_sel) begin
        cfg_err <= 1'b1;
      end else if (cfg_we && !cfg_sel) begin
        if (cfg_wdata[15] && !fresh) viol_order++;
        if (first_addr < 0) first_addr = int'(cfg_wdata[15:0]);
        m_addr = cfg_wdata[15:0];
        m_flag = cfg_wdata[15];
        fresh = 1'b0;
        pending = 1'b1;
        polls = 0;
      end else if (cfg_we) begin
        m_data = cfg_wdata;
        fresh = 1'b1;
      end else if (!cfg_sel) begin
        poll_t.push_back(cyc);
        if (pending && !hang && polls >= flip_after) begin
          if (!m_flag) begin
            m_data = {mem[a+3], mem[a+2], mem[a+1], mem[a]};
            m_flag = 1'b1;
          end else begin
            for (int i = 0; i < 4; i++) mem[a+i] = m_data[8*i +: 8];
            m_flag = 1'b0;
          end
          pending = 1'b0;
        end
        polls++;
        cfg_rdata <= {16'h0, m_flag, m_addr[14:0]};
      end else begin
        if (!m_flag) viol_flag++;
        cfg_rdata <= m_data;
      end
    end
  end

  // scoreboard
  logic [7:0] exp_q[$];
  always @(negedge clk) begin
    if (!rst && rd_valid) begin
      if (exp_q.size() == 0) chk(0, "R3", "unexpected byte", rd_byte, 0);
      else begin
        logic [7:0] e;
        e = exp_q.pop_front();
        chk(rd_byte == e, "R3", "byte value", rd_byte, e);
      end
    end
  end

  logic [31:0] wr_words [2];
  int take_idx = 0;
  always @(negedge clk) begin
    if (!rst && wd_take) begin
      take_idx++;
      wd_word = wr_words[take_idx % 2];
    end
  end

  bit saw_done, saw_err;
  int end_cyc;
  task automatic run_cmd(input bit w, input int pos, input int cnt, input bit exp_err,
                         input int exp_code, input int exp_cnt, input string req);
    int waitc;
    if (!w && !exp_err) for (int i = pos; i < pos + exp_cnt; i++) exp_q.push_back(mem[i]);
    @(negedge clk);
    cmd_valid = 1'b1; cmd_write = w; cmd_pos = LW'(pos); cmd_count = LW'(cnt);
    @(negedge clk);
    cmd_valid = 1'b0;
    waitc = 0;
    while (!(done || err) && waitc < 20000) begin @(negedge clk); waitc++; end
    saw_done = done; saw_err = err; end_cyc = cyc;
    if (exp_err) begin
      chk(saw_err, req, "err pulse", saw_err, 1);
      chk(err_code == 2'(exp_code), req, "err_code", err_code, exp_code);
    end else begin
      chk(saw_done, req, "done pulse", saw_done, 1);
      chk(xfer_count == LW'(exp_cnt), "R12", "xfer_count", xfer_count, exp_cnt);
    end
    chk(exp_q.size() == 0, req, "bytes left", exp_q.size(), 0);
    exp_q.delete();
  endtask

  initial begin
    int ac;
    for (int i = 0; i < MAXL; i++) mem[i] = 8'(i * 7 + 3);
    wr_words[0] = 32'hA1B2C3D4;
    wr_words[1] = 32'h11223344;
    wd_word = wr_words[0];
    repeat (4) @(negedge clk);
    chk(!busy && !cfg_req && !rd_valid && !done && !err, "R11", "reset outputs", busy, 0);
    rst = 1'b0;
    @(negedge clk);
    chk(!busy && !cfg_req, "R11", "idle after reset", busy, 0);

    // unaligned multi-dword read
    flip_after = 2; first_addr = -1;
    run_cmd(0, 5, 9, 0, 0, 9, "R3");
    chk(first_addr == 4, "R1", "first address word", first_addr, 4);
    chk(viol_flag == 0, "R2", "data read before flag", viol_flag, 0);

    flip_after = 0;
    run_cmd(0, 0, 4, 0, 0, 4, "R3");
    run_cmd(0, 7, 1, 0, 0, 1, "R3");

    // clip at max length
    run_cmd(0, 62, 10, 0, 0, 2, "R4");

    // start beyond the end, zero count
    ac = acc_cnt;
    run_cmd(0, 64, 4, 0, 0, 0, "R5");
    run_cmd(0, 70, 4, 0, 0, 0, "R5");
    run_cmd(0, 10, 0, 0, 0, 0, "R5");
    chk(acc_cnt == ac, "R5", "config accesses", acc_cnt - ac, 0);

    // write rejection
    run_cmd(1, 2, 4, 1, 1, 0, "R6");
    run_cmd(1, 0, 6, 1, 1, 0, "R6");
    run_cmd(1, 60, 8, 1, 1, 0, "R6");
    chk(acc_cnt == ac, "R6", "config accesses", acc_cnt - ac, 0);

    // two-dword write
    flip_after = 1;
    run_cmd(1, 8, 8, 0, 0, 8, "R7");
    chk({mem[11], mem[10], mem[9], mem[8]} == 32'hA1B2C3D4, "R7", "dword 0", {mem[11], mem[10], mem[9], mem[8]}, 32'hA1B2C3D4);
    chk({mem[15], mem[14], mem[13], mem[12]} == 32'h11223344, "R7", "dword 1", {mem[15], mem[14], mem[13], mem[12]}, 32'h11223344);
    chk(viol_order == 0, "R7", "address before data", viol_order, 0);
    chk(take_idx == 2, "R7", "wd_take count", take_idx, 2);
    run_cmd(0, 8, 8, 0, 0, 8, "R7");

    // back-off spacing
    flip_after = 5;
    poll_t.delete();
    run_cmd(0, 20, 4, 0, 0, 4, "R9");
    chk(poll_t.size() == 6, "R9", "status reads", poll_t.size(), 6);
    if (poll_t.size() == 6) begin
      int d[5];
      for (int i = 0; i < 5; i++) d[i] = poll_t[i+1] - poll_t[i];
      chk(d[1] - d[0] == 2, "R9", "first doubling", d[1] - d[0], 2);
      chk(d[2] - d[1] == 4, "R9", "second doubling", d[2] - d[1], 4);
      chk(d[3] == d[2] && d[4] == d[3], "R9", "capped gap", d[4] - d[2], 0);
    end

    // timeout
    hang = 1; poll_t.delete();
    run_cmd(0, 0, 4, 1, 2, 0, "R8");
    if (poll_t.size() > 0) begin
      int el;
      el = end_cyc - poll_t[0];
      chk(el >= 299 && el <= 320, "R8", "timeout latency", el, 300);
    end
    hang = 0;

    // config failure
    err_mode = 2; flip_after = 0;
    run_cmd(0, 0, 8, 1, 3, 0, "R10");
    ac = acc_cnt;
    repeat (20) @(negedge clk);
    chk(acc_cnt == ac && !busy, "R10", "accesses after failure", acc_cnt - ac, 0);
    err_mode = 0;

    // command while busy is ignored
    flip_after = 3;
    for (int i = 16; i < 20; i++) exp_q.push_back(mem[i]);
    @(negedge clk);
    cmd_valid = 1'b1; cmd_write = 1'b0; cmd_pos = 16; cmd_count = 4;
    @(negedge clk);
    cmd_pos = 40; cmd_count = 4;
    chk(busy, "R11", "busy after accept", busy, 1);
    @(negedge clk);
    @(negedge clk);
    cmd_valid = 1'b0;
    begin
      int w = 0;
      while (!done && w < 5000) begin @(negedge clk); w++; end
    end
    chk(done && !busy && xfer_count == 4, "R11", "first command completes", xfer_count, 4);
    begin
      int extra = 0;
      repeat (30) begin @(negedge clk); if (done || busy || rd_valid) extra++; end
      chk(extra == 0, "R11", "ignored command activity", extra, 0);
    end
    chk(exp_q.size() == 0, "R11", "bytes left", exp_q.size(), 0);

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    bad++; total++;
    $display("FAIL watchdog: actual=timeout expected=completion");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule